// File: doc/BRIEF.md
# Data FIFO with Threshold-Driven DMA Requests

This block is the word buffer that sits between a host register port and the card-side data engine of a memory-card host controller. It holds up to 32 words of 16 bits in a circular store, addressed by a head pointer and an occupancy count. The host pushes words with a data-register write and pops them with a data-register read. The card side pushes words while receiving and pops words while sending.

After every change, the block compares the occupancy against two programmable levels: a high-water level for the receive direction and a low-water level for the transmit direction. For each direction, a crossed threshold is reported in one of two ways, chosen by that direction's DMA enable. It either raises a level-sensitive DMA request line or sets a status flag. When DMA is selected, the status flag for that direction is held clear.

Top module: `fifo_level_dma`

## Requirements
- R1: After reset the occupancy is 0 and all four indications are low. The low-water level resets to 0 and the high-water level resets to 31, so with reset settings in the receive direction the high-water flag appears only at 32 words.
- R2: Words leave the store in the order they entered, across wrap-around of the 32-entry circular store. `rd_word` always shows the head word.
- R3: A push while the store holds 32 words is ignored: the occupancy stays 32 and the word never appears at the output.
- R4: A host pop while the store is empty leaves the occupancy at 0. `rd_word` keeps showing the stale word at the head slot.
- R5: Receive direction (`dir_rx`=1) with receive DMA enabled (config bit 15): when occupancy > high-water level (config bits 12:8), `rx_dma_req` is high and `af_flag` is low.
- R6: Receive direction with receive DMA disabled: under the same condition `af_flag` is high and `rx_dma_req` is low.
- R7: Transmit direction (`dir_rx`=0): when occupancy < low-water level (config bits 4:0), `tx_dma_req` is high if transmit DMA is enabled (config bit 7). Otherwise `ae_flag` is high.
- R8: When no transfer is active and the store is empty, all four indications are low. With a transfer inactive but words present, the threshold rules still apply.
- R9: When a direction's condition is false, including when the other direction is selected, its request line and its flag are both low.
- R10: The indications are registered. They reflect the occupancy and configuration held after a clock edge one edge later.
- R11: Card-side pushes count only during an active receive transfer, and card-side pops only during an active transmit transfer. A host push or pop in the same cycle takes priority over the card-side one, which is then dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_active | input | 1 | A data transfer is in progress |
| dir_rx | input | 1 | 1 = card to host, 0 = host to card |
| cfg_we | input | 1 | Load the buffer configuration word |
| cfg_word | input | 16 | Configuration: bit 15 rx DMA enable, 12:8 high-water, bit 7 tx DMA enable, 4:0 low-water |
| host_wr | input | 1 | Host data-register write (push) |
| host_wdata | input | 16 | Host word to push |
| host_rd | input | 1 | Host data-register read (pop) |
| card_push | input | 1 | Card side delivers a word |
| card_wdata | input | 16 | Card word to push |
| card_pop | input | 1 | Card side consumes the head word |
| rd_word | output | 16 | Current head word |
| fill_level | output | 6 | Occupancy, 0 to 32 |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| af_flag | output | 1 | High-water status flag |
| ae_flag | output | 1 | Low-water status flag |

## Verification
The threshold properties assume that the direction, transfer flag and configuration stay put for the edge that follows the condition. They also assume that the block sees no push and no pop from two agents on the same side in the full and empty corner checks. The bench keeps to this in two ways. It changes one input per operation, on the falling edge. It then spends a quiet cycle before sampling, so the registered indications have settled against a stable occupancy. The sweeps cover every high-water and low-water value, with DMA on and off, at each fill from 0 to 32.

// File: rtl/fifo_level_dma_pkg.sv
package fifo_level_dma_pkg;

  // registered indications of one evaluation
  typedef struct packed {
    logic rx_req;
    logic tx_req;
    logic af_flag;
    logic ae_flag;
  } lvl_out_t;

  // threshold decision: idle and empty clears everything, otherwise each
  // direction routes its crossing to either a DMA request or a flag
  function automatic lvl_out_t eval_levels(input logic xfer, input logic dir_rx,
                                           input logic rx_en, input logic tx_en,
                                           input int unsigned fill,
                                           input int unsigned hi_lvl,
                                           input int unsigned lo_lvl);
    lvl_out_t r;
    logic rx_hit;
    logic tx_hit;
    r = '0;
    if (xfer || fill != 0) begin
      rx_hit    = dir_rx && (fill > hi_lvl);
      tx_hit    = !dir_rx && (fill < lo_lvl);
      r.rx_req  = rx_hit && rx_en;
      r.af_flag = rx_hit && !rx_en;
      r.tx_req  = tx_hit && tx_en;
      r.ae_flag = tx_hit && !tx_en;
    end
    return r;
  endfunction

endpackage

// File: rtl/fifo_level_dma_store.sv
module fifo_level_dma_store #(
  parameter int WIDTH  = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WIDTH-1:0]  push_data,
  input  logic              pop,
  output logic [WIDTH-1:0]  head_data,
  output logic [ADDR_W:0]   fill
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = ADDR_W + 1;

  logic [WIDTH-1:0]  mem [DEPTH];
  logic [ADDR_W-1:0] head_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_d;
  logic [ADDR_W-1:0] wr_idx;
  logic              push_ok;
  logic              pop_ok;

  // full and empty are judged on the count before this cycle's operations
  assign push_ok = push && (cnt_q != CNT_W'(DEPTH));
  assign pop_ok  = pop && (cnt_q != '0);
  assign wr_idx  = head_q + cnt_q[ADDR_W-1:0];

  always_comb begin
    cnt_d = cnt_q;
    if (push_ok && !pop_ok)      cnt_d = cnt_q + 1'b1;
    else if (pop_ok && !push_ok) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_idx] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (pop_ok) head_q <= head_q + 1'b1;
    end
  end

  assign head_data = mem[head_q];
  assign fill      = cnt_q;
endmodule

// File: rtl/fifo_level_dma_eval.sv
module fifo_level_dma_eval
  import fifo_level_dma_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_active,
  input  logic              dir_rx,
  input  logic              rx_en,
  input  logic              tx_en,
  input  logic [ADDR_W-1:0] hi_lvl,
  input  logic [ADDR_W-1:0] lo_lvl,
  input  logic [ADDR_W:0]   fill,
  output lvl_out_t          lvl_q
);
  lvl_out_t lvl_d;

  assign lvl_d = eval_levels(xfer_active, dir_rx, rx_en, tx_en,
                             32'(fill), 32'(hi_lvl), 32'(lo_lvl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_d;
  end
endmodule

// File: rtl/fifo_level_dma.sv
module fifo_level_dma
  import fifo_level_dma_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int ADDR_W = 5    // 2..6; levels sit in fixed config fields
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_active,
  input  logic              dir_rx,
  input  logic              cfg_we,
  input  logic [15:0]       cfg_word,
  input  logic              host_wr,
  input  logic [WIDTH-1:0]  host_wdata,
  input  logic              host_rd,
  input  logic              card_push,
  input  logic [WIDTH-1:0]  card_wdata,
  input  logic              card_pop,
  output logic [WIDTH-1:0]  rd_word,
  output logic [ADDR_W:0]   fill_level,
  output logic              rx_dma_req,
  output logic              tx_dma_req,
  output logic              af_flag,
  output logic              ae_flag
);
  localparam int RX_EN_BIT = 15;
  localparam int HI_LSB    = 8;
  localparam int TX_EN_BIT = 7;
  localparam int LO_LSB    = 0;

  logic              cfg_rx_en;
  logic              cfg_tx_en;
  logic [ADDR_W-1:0] cfg_hi;
  logic [ADDR_W-1:0] cfg_lo;
  logic              cfg_unused;

  // reserved bits of the configuration word
  assign cfg_unused = ^{cfg_word[14:HI_LSB+ADDR_W], cfg_word[6:LO_LSB+ADDR_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_rx_en <= 1'b0;
      cfg_tx_en <= 1'b0;
      cfg_hi    <= '1;
      cfg_lo    <= '0;
    end else if (cfg_we) begin
      cfg_rx_en <= cfg_word[RX_EN_BIT];
      cfg_tx_en <= cfg_word[TX_EN_BIT];
      cfg_hi    <= cfg_word[HI_LSB +: ADDR_W];
      cfg_lo    <= cfg_word[LO_LSB +: ADDR_W];
    end
  end

  // source selection: host side wins over the card side
  logic             card_push_ok;
  logic             card_pop_ok;
  logic             push_any;
  logic             pop_any;
  logic [WIDTH-1:0] push_word;

  assign card_push_ok = card_push && xfer_active && dir_rx;
  assign card_pop_ok  = card_pop && xfer_active && !dir_rx;
  assign push_any     = host_wr || card_push_ok;
  assign pop_any      = host_rd || card_pop_ok;
  assign push_word    = host_wr ? host_wdata : card_wdata;

  fifo_level_dma_store #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_any),
    .push_data (push_word),
    .pop       (pop_any),
    .head_data (rd_word),
    .fill      (fill_level)
  );

  lvl_out_t lvl;

  fifo_level_dma_eval #(.ADDR_W(ADDR_W)) u_eval (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfer_active (xfer_active),
    .dir_rx      (dir_rx),
    .rx_en       (cfg_rx_en),
    .tx_en       (cfg_tx_en),
    .hi_lvl      (cfg_hi),
    .lo_lvl      (cfg_lo),
    .fill        (fill_level),
    .lvl_q       (lvl)
  );

  assign rx_dma_req = lvl.rx_req;
  assign tx_dma_req = lvl.tx_req;
  assign af_flag    = lvl.af_flag;
  assign ae_flag    = lvl.ae_flag;
endmodule

// File: rtl/fifo_level_dma_chk.sv
module fifo_level_dma_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xfer_active,
  input logic              dir_rx,
  input logic              host_wr,
  input logic              host_rd,
  input logic              card_push,
  input logic              card_pop,
  input logic [ADDR_W:0]   fill_level,
  input logic              rx_dma_req,
  input logic              tx_dma_req,
  input logic              af_flag,
  input logic              ae_flag,
  input logic              rx_en,
  input logic              tx_en,
  input logic [ADDR_W-1:0] hi_lvl,
  input logic [ADDR_W-1:0] lo_lvl
);
  localparam int DEPTH = 1 << ADDR_W;

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= (ADDR_W+1)'(DEPTH));

  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level == (ADDR_W+1)'(DEPTH) && host_wr && !host_rd && !card_pop)
      |=> fill_level == (ADDR_W+1)'(DEPTH));

  p_empty_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level == '0 && host_rd && !host_wr && !card_push) |=> fill_level == '0);

  p_rx_dma_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_active && dir_rx && rx_en && fill_level > {1'b0, hi_lvl})
      |=> (rx_dma_req && !af_flag));

  p_af_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_active && dir_rx && !rx_en && fill_level > {1'b0, hi_lvl})
      |=> (af_flag && !rx_dma_req));

  p_tx_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_active && !dir_rx && fill_level < {1'b0, lo_lvl})
      |=> (tx_dma_req == $past(tx_en) && ae_flag == !$past(tx_en)));

  p_idle_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_active && fill_level == '0)
      |=> (!rx_dma_req && !tx_dma_req && !af_flag && !ae_flag));

  p_one_side_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rx_dma_req || af_flag, tx_dma_req || ae_flag}) <= 1);
endmodule

bind fifo_level_dma fifo_level_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .xfer_active (xfer_active),
  .dir_rx      (dir_rx),
  .host_wr     (host_wr),
  .host_rd     (host_rd),
  .card_push   (card_push),
  .card_pop    (card_pop),
  .fill_level  (fill_level),
  .rx_dma_req  (rx_dma_req),
  .tx_dma_req  (tx_dma_req),
  .af_flag     (af_flag),
  .ae_flag     (ae_flag),
  .rx_en       (cfg_rx_en),
  .tx_en       (cfg_tx_en),
  .hi_lvl      (cfg_hi),
  .lo_lvl      (cfg_lo)
);

// File: tb/fifo_level_dma_bench.sv
`timescale 1ns/1ps
module fifo_level_dma_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfer_active = 1'b0;
  logic        dir_rx = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_word = '0;
  logic        host_wr = 1'b0;
  logic [15:0] host_wdata = '0;
  logic        host_rd = 1'b0;
  logic        card_push = 1'b0;
  logic [15:0] card_wdata = '0;
  logic        card_pop = 1'b0;
  logic [15:0] rd_word;
  logic [5:0]  fill_level;
  logic        rx_dma_req, tx_dma_req, af_flag, ae_flag;

  always #10 clk = ~clk;

  fifo_level_dma u_fifo_level_dma (
    .clk(clk), .rst_n(rst_n), .xfer_active(xfer_active), .dir_rx(dir_rx),
    .cfg_we(cfg_we), .cfg_word(cfg_word), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rd(host_rd), .card_push(card_push),
    .card_wdata(card_wdata), .card_pop(card_pop), .rd_word(rd_word),
    .fill_level(fill_level), .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req),
    .af_flag(af_flag), .ae_flag(ae_flag));

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // bench model of the store
  logic [15:0] bm [32];
  int bh = 0;
  int bc = 0;
  // bench copy of configuration
  bit m_rxe = 0, m_txe = 0;
  int m_hi = 31, m_lo = 0;
  logic [15:0] seq = 16'h1000;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int expect_ind();
    bit rx, tx;
    if (!xfer_active && bc == 0) return 0;
    rx = dir_rx && (bc > m_hi);
    tx = !dir_rx && (bc < m_lo);
    // {rx_req, tx_req, af, ae}
    return ((rx && m_rxe) ? 8 : 0) + ((tx && m_txe) ? 4 : 0) +
           ((rx && !m_rxe) ? 2 : 0) + ((tx && !m_txe) ? 1 : 0);
  endfunction

  task automatic chk_ind(string req);
    chk(req, {28'd0, rx_dma_req, tx_dma_req, af_flag, ae_flag}, expect_ind());
  endtask

  task automatic model_push(logic [15:0] d);
    if (bc < 32) begin bm[(bh + bc) % 32] = d; bc++; end
  endtask

  task automatic model_pop();
    if (bc > 0) begin bh = (bh + 1) % 32; bc--; end
  endtask

  task automatic set_cfg(bit rxe, int hi, bit txe, int lo);
    cfg_we = 1'b1;
    cfg_word = {rxe, 2'b00, hi[4:0], txe, 2'b00, lo[4:0]};
    tick();
    cfg_we = 1'b0;
    m_rxe = rxe; m_txe = txe; m_hi = hi; m_lo = lo;
  endtask

  task automatic hw(logic [15:0] d);
    host_wr = 1'b1; host_wdata = d;
    tick();
    host_wr = 1'b0;
    model_push(d);
  endtask

  task automatic hr(string req);
    host_rd = 1'b1;
    #1 chk(req, rd_word, bm[bh]);
    tick();
    host_rd = 1'b0;
    model_pop();
  endtask

  initial begin
    repeat (3) tick();
    // R1 reset state
    chk("R1 fill", fill_level, 0);
    chk("R1 ind", {rx_dma_req, tx_dma_req, af_flag, ae_flag}, 0);
    rst_n = 1'b1;
    tick();
    xfer_active = 1'b1; dir_rx = 1'b0;
    tick();
    chk("R1 lo level 0 no ae", ae_flag, 0);
    // reset high-water level 31 in receive direction
    dir_rx = 1'b1;
    for (int i = 0; i < 31; i++) begin hw(seq); seq++; end
    tick();
    chk("R1 no af at 31", af_flag, 0);
    hw(seq); seq++;
    tick();
    chk("R1 af at 32", af_flag, 1);
    for (int i = 0; i < 29; i++) hr("R2 order");
    tick();
    chk("R2 fill after drain", fill_level, bc);

    // receive sweep over every high-water level, DMA off/on
    for (int en = 0; en < 2; en++) begin
      for (int hi = 0; hi < 32; hi++) begin
        while (bc > 0) hr("R2 order");
        set_cfg(en[0], hi, 1'b0, 0);
        tick();
        chk_ind("R5 R6 R9 empty");
        for (int i = 0; i < 32; i++) begin
          hw(seq); seq++;
          tick();
          chk_ind(en ? "R5 R9 fill" : "R6 R9 fill");
        end
        hw(16'hDEAD);
        tick();
        chk("R3 full write fill", fill_level, 32);
        for (int i = 0; i < 32; i++) begin
          hr("R2 R3 order");
          tick();
          chk_ind(en ? "R5 R9 drain" : "R6 R9 drain");
        end
        hr("R4 stale head");
        tick();
        chk("R4 empty read fill", fill_level, 0);
      end
    end

    // transmit sweep over every low-water level, DMA off/on
    dir_rx = 1'b0;
    for (int en = 0; en < 2; en++) begin
      for (int lo = 0; lo < 32; lo++) begin
        set_cfg(1'b0, 31, en[0], lo);
        tick();
        chk_ind("R7 R9 empty");
        for (int i = 0; i < 32; i++) begin
          hw(seq); seq++;
          tick();
          chk_ind("R7 R9 fill");
        end
        for (int i = 0; i < 32; i++) begin
          hr("R2 order");
          tick();
          chk_ind("R7 R9 drain");
        end
      end
    end

    // R8 idle and empty
    set_cfg(1'b0, 31, 1'b0, 5);
    xfer_active = 1'b0;
    tick(); tick();
    chk("R8 idle empty", {rx_dma_req, tx_dma_req, af_flag, ae_flag}, 0);
    xfer_active = 1'b1;
    tick();
    chk("R8 active empty ae", ae_flag, 1);
    xfer_active = 1'b0;
    hw(16'h0A0A);
    tick();
    chk("R8 idle nonempty ae", ae_flag, 1);
    hr("R2 order");
    tick();
    chk("R8 idle drained", {rx_dma_req, tx_dma_req, af_flag, ae_flag}, 0);

    // R10 one-edge lag
    xfer_active = 1'b1; dir_rx = 1'b1;
    set_cfg(1'b0, 0, 1'b0, 0);
    tick();
    chk("R10 before", af_flag, 0);
    host_wr = 1'b1; host_wdata = 16'h5151;
    tick();
    host_wr = 1'b0; model_push(16'h5151);
    chk("R10 fill now", fill_level, 1);
    chk("R10 flag lags", af_flag, 0);
    tick();
    chk("R10 flag after", af_flag, 1);
    // R9 direction flip lowers the flag
    dir_rx = 1'b0;
    tick();
    chk("R9 flip", af_flag, 0);
    hr("R2 order");

    // R11 card-side gating and priority
    dir_rx = 1'b0;
    card_push = 1'b1; card_wdata = 16'hC0C0;
    tick();
    card_push = 1'b0;
    chk("R11 card push ignored in tx", fill_level, 0);
    dir_rx = 1'b1;
    card_push = 1'b1; card_wdata = 16'hC1C1;
    tick();
    card_push = 1'b0; model_push(16'hC1C1);
    chk("R11 card push rx", fill_level, 1);
    #1 chk("R11 card word", rd_word, 16'hC1C1);
    host_wr = 1'b1; host_wdata = 16'hB2B2;
    card_push = 1'b1; card_wdata = 16'hC3C3;
    tick();
    host_wr = 1'b0; card_push = 1'b0; model_push(16'hB2B2);
    chk("R11 host priority fill", fill_level, 2);
    card_pop = 1'b1;
    tick();
    card_pop = 1'b0;
    chk("R11 card pop ignored in rx", fill_level, 2);
    dir_rx = 1'b0;
    card_pop = 1'b1;
    tick();
    card_pop = 1'b0; model_pop();
    chk("R11 card pop tx", fill_level, 1);
    #1 chk("R11 host word kept", rd_word, 16'hB2B2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule